// File: doc/BRIEF.md
# Master Clock Source Switch Controller

This block chooses which of three clock sources drives the master clock: a fast internal oscillator, a slow internal oscillator or an external clock. Each source is modelled by an enable output and a ready strobe input. Software uses a small byte-wide register bus. It writes a one-byte selection code into a target register and then sets a start bit. The controller holds a busy flag until the chosen oscillator has proven stable, and then moves the master status to the new code. Software can cancel a pending switch by clearing the busy flag.

The same block also produces the CPU clock enable. A two-bit source prescaler and a three-bit CPU prescaler together select a division of 2^(s+c). The division is applied as a single-cycle enable pulse taken from one free-running counter.

Top module: `clk_switch_ctrl`

## Requirements
- R1: Selection codes are 0xE1 for the fast internal oscillator (source index 0), 0xD2 for the slow internal oscillator (index 1) and 0xB4 for the external clock (index 2). Address 2 is a read-only master-status register holding the code of the current master. Address 3 is the switch target register.
- R2: A write to address 3 is ignored while the busy flag is set, and also when the byte is not one of the three codes. The target register then keeps its previous value.
- R3: The switch control register is at address 4, with busy at bit 0, start at bit 1, interrupt enable at bit 2 and switch flag at bit 3. Start reads as 0. Writing start=1 while not busy sets busy when the target differs from the master. When the target equals the master, busy stays 0 and nothing changes. On completion, master status takes the target code in the same cycle that busy clears.
- R4: Writing address 4 with bit 0 = 0 while busy cancels the switch. Busy clears on the next edge and master status keeps the old code. This cancel takes priority over a completion on the same edge.
- R5: The switch flag is set on completion and cleared by a write to address 4 with bit 3 = 0; setting wins over clearing. irq_o equals the flag AND the interrupt-enable bit.
- R6: A switch completes only after the target's ready input has been sampled high on two consecutive clock edges while busy. Master status changes on the second of those edges. A single-edge ready pulse does not complete the switch.
- R7: Address 0 holds the fast oscillator enable (bit 0), its ready (bit 1), the slow enable (bit 2) and its ready (bit 3). Address 1 holds the external enable (bit 0) and its ready (bit 1). Ready bits are read-only and follow osc_ready_i. osc_enable_o[i] is the enable bit OR (source i is the master) OR (busy and source i is the target).
- R8: Address 5 holds the source prescaler in bits [4:3] and the CPU prescaler in bits [2:0]. cpu_tick_o pulses for one cycle every 2^(s+c) cycles, and is high every cycle when s+c = 0. A write to address 5 restarts the counter, so the first pulse falls in the 2^(s+c)-th cycle after the write edge.
- R9: After reset: master and target read 0xE1, the divider reads 0x18 (divide by 8), address 4 reads 0, the fast enable is 1, and the other enables are 0. Unmapped addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| osc_ready_i | input | 3 | Ready strobes: [0] fast internal, [1] slow internal, [2] external |
| osc_enable_o | output | 3 | Oscillator enables, same bit order |
| irq_o | output | 1 | Switch interrupt |
| cpu_tick_o | output | 1 | Divided CPU clock enable pulse |

## Verification
A wrong busy or sequencing state appears at the ports within one cycle. osc_enable_o drops the forced target bit, address 4 reads the wrong busy bit, and the master-status code moves one edge early or late relative to the second qualifying ready sample. A corrupted flag shows on irq_o in the same cycle once interrupts are enabled. A wrong prescaler counter shows as a cpu_tick_o pulse in the wrong cycle within one division period after the last divider write. The bench compares every port against its behavioural model on every clock, so each of these errors is reported in the cycle where it first becomes visible.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int NUM_SRC  = 3;
    localparam int CODE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int SDIV_W   = 2;
    localparam int CDIV_W   = 3;

    localparam logic [CODE_W-1:0] CODE_FAST = 8'hE1;
    localparam logic [CODE_W-1:0] CODE_SLOW = 8'hD2;
    localparam logic [CODE_W-1:0] CODE_EXT  = 8'hB4;

    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_EXT  = 2'd2
    } src_e;

    typedef enum logic [ADDR_W-1:0] {
        A_OSC_INT = 3'd0,
        A_OSC_EXT = 3'd1,
        A_MSTAT   = 3'd2,
        A_TARGET  = 3'd3,
        A_SWCTL   = 3'd4,
        A_DIV     = 3'd5
    } addr_e;

    // switch control byte, low nibble
    typedef struct packed {
        logic flag;
        logic ie;
        logic start;
        logic busy;
    } swctl_t;

    typedef struct packed {
        logic [SDIV_W-1:0] sdiv;
        logic [CDIV_W-1:0] cdiv;
    } div_t;

    function automatic logic code_valid(input logic [CODE_W-1:0] c);
        return (c == CODE_FAST) || (c == CODE_SLOW) || (c == CODE_EXT);
    endfunction

    function automatic src_e code_to_src(input logic [CODE_W-1:0] c);
        case (c)
            CODE_SLOW: return SRC_SLOW;
            CODE_EXT:  return SRC_EXT;
            default:   return SRC_FAST;
        endcase
    endfunction

    function automatic logic [NUM_SRC-1:0] src_onehot(input src_e s);
        return NUM_SRC'(1) << s;
    endfunction

endpackage

// File: rtl/csw_switch_fsm.sv
module csw_switch_fsm
    import csw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tgt_wr,
    input  logic [CODE_W-1:0]   tgt_data,
    input  logic                ctl_wr,
    input  swctl_t              ctl_data,
    input  logic [NUM_SRC-1:0]  osc_ready,
    output logic                busy,
    output logic                flag,
    output logic                ie,
    output logic [CODE_W-1:0]   master_code,
    output logic [CODE_W-1:0]   target_code
);

    logic seen;
    src_e tgt_src;
    logic tgt_rdy;
    logic abort_req;
    logic start_req;
    logic complete;

    assign tgt_src   = code_to_src(target_code);
    assign tgt_rdy   = osc_ready[tgt_src];
    assign abort_req = ctl_wr && busy && !ctl_data.busy;
    assign start_req = ctl_wr && !busy && ctl_data.start && (target_code != master_code);
    assign complete  = busy && !abort_req && seen && tgt_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            master_code <= CODE_FAST;
            target_code <= CODE_FAST;
            busy        <= 1'b0;
            seen        <= 1'b0;
            flag        <= 1'b0;
            ie          <= 1'b0;
        end else begin
            if (tgt_wr && !busy && code_valid(tgt_data))
                target_code <= tgt_data;
            if (ctl_wr)
                ie <= ctl_data.ie;
            seen <= busy && tgt_rdy && !abort_req;
            if (start_req)
                busy <= 1'b1;
            else if (abort_req || complete)
                busy <= 1'b0;
            if (complete)
                master_code <= target_code;
            if (complete)
                flag <= 1'b1;
            else if (ctl_wr && !ctl_data.flag)
                flag <= 1'b0;
        end
    end

endmodule

// File: rtl/csw_osc_ctrl.sv
module csw_osc_ctrl
    import csw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                int_wr,
    input  logic [1:0]          int_en,
    input  logic                ext_wr,
    input  logic                ext_en,
    input  logic                busy,
    input  logic [CODE_W-1:0]   master_code,
    input  logic [CODE_W-1:0]   target_code,
    output logic [NUM_SRC-1:0]  en_q,
    output logic [NUM_SRC-1:0]  osc_enable_o
);

    src_e m_src;
    src_e t_src;

    assign m_src = code_to_src(master_code);
    assign t_src = code_to_src(target_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= src_onehot(SRC_FAST);
        end else begin
            if (int_wr) begin
                en_q[SRC_FAST] <= int_en[0];
                en_q[SRC_SLOW] <= int_en[1];
            end
            if (ext_wr)
                en_q[SRC_EXT] <= ext_en;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign osc_enable_o[i] = en_q[i]
                               | (m_src == src_e'(i))
                               | (busy && (t_src == src_e'(i)));
    end

endmodule

// File: rtl/csw_prescaler.sv
module csw_prescaler
    import csw_pkg::*;
#(
    parameter int S_W = SDIV_W,
    parameter int C_W = CDIV_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        div_wr,
    input  div_t        div_data,
    output div_t        div_q,
    output logic        tick
);

    localparam int EXP_MAX = ((1 << S_W) - 1) + ((1 << C_W) - 1);
    localparam int EXP_W   = $clog2(EXP_MAX + 1);
    localparam int CNT_W   = EXP_MAX;

    logic [CNT_W-1:0] cnt;
    logic [EXP_W-1:0] expo;
    logic [CNT_W:0]   full;
    logic [CNT_W-1:0] mask;

    assign expo = EXP_W'(div_q.sdiv) + EXP_W'(div_q.cdiv);
    assign full = (CNT_W + 1)'(1) << expo;
    assign mask = CNT_W'(full - 1'b1);
    assign tick = ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q.sdiv <= '1;
            div_q.cdiv <= '0;
            cnt        <= '0;
        end else if (div_wr) begin
            div_q <= div_data;
            cnt   <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
    import csw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CODE_W-1:0]   bus_wdata,
    output logic [CODE_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0]  osc_ready_i,
    output logic [NUM_SRC-1:0]  osc_enable_o,
    output logic                irq_o,
    output logic                cpu_tick_o
);

    addr_e               sel;
    logic                busy;
    logic                sw_flag;
    logic                sw_ie;
    logic [CODE_W-1:0]   master_code;
    logic [CODE_W-1:0]   target_code;
    logic [NUM_SRC-1:0]  en_q;
    div_t                div_q;
    swctl_t              ctl_wdata;
    div_t                div_wdata;

    assign sel       = addr_e'(bus_addr);
    assign ctl_wdata = swctl_t'(bus_wdata[3:0]);
    assign div_wdata = div_t'(bus_wdata[SDIV_W+CDIV_W-1:0]);

    csw_switch_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tgt_wr      (bus_wr && (sel == A_TARGET)),
        .tgt_data    (bus_wdata),
        .ctl_wr      (bus_wr && (sel == A_SWCTL)),
        .ctl_data    (ctl_wdata),
        .osc_ready   (osc_ready_i),
        .busy        (busy),
        .flag        (sw_flag),
        .ie          (sw_ie),
        .master_code (master_code),
        .target_code (target_code)
    );

    csw_osc_ctrl u_osc (
        .clk          (clk),
        .rst          (rst),
        .int_wr       (bus_wr && (sel == A_OSC_INT)),
        .int_en       ({bus_wdata[2], bus_wdata[0]}),
        .ext_wr       (bus_wr && (sel == A_OSC_EXT)),
        .ext_en       (bus_wdata[0]),
        .busy         (busy),
        .master_code  (master_code),
        .target_code  (target_code),
        .en_q         (en_q),
        .osc_enable_o (osc_enable_o)
    );

    csw_prescaler #(
        .S_W (SDIV_W),
        .C_W (CDIV_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .div_wr   (bus_wr && (sel == A_DIV)),
        .div_data (div_wdata),
        .div_q    (div_q),
        .tick     (cpu_tick_o)
    );

    assign irq_o = sw_flag && sw_ie;

    always_comb begin
        bus_rdata = '0;
        case (sel)
            A_OSC_INT: bus_rdata = {4'b0, osc_ready_i[SRC_SLOW], en_q[SRC_SLOW],
                                    osc_ready_i[SRC_FAST], en_q[SRC_FAST]};
            A_OSC_EXT: bus_rdata = {6'b0, osc_ready_i[SRC_EXT], en_q[SRC_EXT]};
            A_MSTAT:   bus_rdata = master_code;
            A_TARGET:  bus_rdata = target_code;
            A_SWCTL:   bus_rdata = {4'b0, sw_flag, sw_ie, 1'b0, busy};
            A_DIV:     bus_rdata = {{(CODE_W-SDIV_W-CDIV_W){1'b0}}, div_q};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/csw_checks.sv
module csw_checks
    import csw_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                flag,
    input logic [CODE_W-1:0]   master_code,
    input logic [CODE_W-1:0]   target_code,
    input logic [NUM_SRC-1:0]  osc_ready_i,
    input logic [NUM_SRC-1:0]  osc_enable_o
);

    logic               tgt_rdy;
    logic [NUM_SRC-1:0] m_oh;

    assign tgt_rdy = osc_ready_i[code_to_src(target_code)];
    assign m_oh    = src_onehot(code_to_src(master_code));

    AST_MASTER_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
        code_valid(master_code)); // R1

    AST_TARGET_LOCKED: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(target_code)); // R2

    AST_MASTER_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(master_code) |-> $fell(busy)); // R3

    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $fell(busy)); // R5

    AST_READY_TWO_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$stable(master_code)) |-> ($past(tgt_rdy) && $past(tgt_rdy, 2))); // R6

    AST_MASTER_OSC_ON: assert property (@(posedge clk) disable iff (rst)
        (osc_enable_o & m_oh) == m_oh); // R7

endmodule

bind clk_switch_ctrl csw_checks u_csw_checks (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .flag         (sw_flag),
    .master_code  (master_code),
    .target_code  (target_code),
    .osc_ready_i  (osc_ready_i),
    .osc_enable_o (osc_enable_o)
);

// File: tb/test_clk_switch_ctrl.sv
module test_clk_switch_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [2:0] osc_ready_i = 3'b001;
    logic [2:0] osc_enable_o;
    logic       irq_o;
    logic       cpu_tick_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    clk_switch_ctrl i_clk_switch_ctrl (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .osc_ready_i  (osc_ready_i),
        .osc_enable_o (osc_enable_o),
        .irq_o        (irq_o),
        .cpu_tick_o   (cpu_tick_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_master, m_target;
    bit         m_busy, m_seen, m_flag, m_ie;
    bit [2:0]   m_en;
    int         m_sdiv, m_cdiv, m_cnt;

    function automatic int idx_of(input logic [7:0] c);
        if (c == 8'hE1) return 0;
        if (c == 8'hD2) return 1;
        return 2;
    endfunction

    function automatic bit valid_code(input logic [7:0] c);
        return (c == 8'hE1) || (c == 8'hD2) || (c == 8'hB4);
    endfunction

    always @(posedge clk) begin : model
        bit t_rdy, abrt, done, strt, wc;
        logic [7:0] d;
        d = bus_wdata;
        if (rst) begin
            m_master = 8'hE1; m_target = 8'hE1;
            m_busy = 0; m_seen = 0; m_flag = 0; m_ie = 0;
            m_en = 3'b001; m_sdiv = 3; m_cdiv = 0; m_cnt = 0;
        end else begin
            wc    = bus_wr && (bus_addr == 3'd4);
            t_rdy = osc_ready_i[idx_of(m_target)];
            abrt  = wc && m_busy && !d[0];
            done  = m_busy && !abrt && m_seen && t_rdy;
            strt  = wc && !m_busy && d[1] && (m_target != m_master);
            m_seen = m_busy && t_rdy && !abrt;
            if (bus_wr && bus_addr == 3'd3 && !m_busy && valid_code(d)) m_target = d;
            if (done) m_master = m_target;
            if (strt) m_busy = 1; else if (abrt || done) m_busy = 0;
            if (done) m_flag = 1; else if (wc && !d[3]) m_flag = 0;
            if (wc) m_ie = d[2];
            if (bus_wr && bus_addr == 3'd0) begin m_en[0] = d[0]; m_en[1] = d[2]; end
            if (bus_wr && bus_addr == 3'd1) m_en[2] = d[0];
            if (bus_wr && bus_addr == 3'd5) begin
                m_sdiv = d[4:3]; m_cdiv = d[2:0]; m_cnt = 0;
            end else begin
                m_cnt = (m_cnt + 1) % 1024;
            end
        end
    end

    function automatic logic [7:0] exp_rdata();
        case (bus_addr)
            3'd0: return {4'b0, osc_ready_i[1], m_en[1], osc_ready_i[0], m_en[0]};
            3'd1: return {6'b0, osc_ready_i[2], m_en[2]};
            3'd2: return m_master;
            3'd3: return m_target;
            3'd4: return {4'b0, m_flag, m_ie, 1'b0, m_busy};
            3'd5: return 8'(m_sdiv * 8 + m_cdiv);
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit [2:0] exp_en();
        bit [2:0] e;
        for (int i = 0; i < 3; i++)
            e[i] = m_en[i] || (idx_of(m_master) == i) || (m_busy && idx_of(m_target) == i);
        return e;
    endfunction

    function automatic bit exp_tick();
        int mask;
        mask = (1 << (m_sdiv + m_cdiv)) - 1;
        return (m_cnt & mask) == mask;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always begin
        @(posedge clk);
        #5;
        if (!rst) begin
            chk("R1 rdata vs model", bus_rdata, exp_rdata());
            chk("R7 osc_enable_o vs model", osc_enable_o, exp_en());
            chk("R5 irq_o vs model", irq_o, m_flag && m_ie);
            chk("R8 cpu_tick_o vs model", cpu_tick_o, exp_tick());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [2:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, e);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_now(a, e, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ticks;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd_now(3'd0, 8'h03, "R9 osc int reg");
        rd_now(3'd1, 8'h00, "R9 osc ext reg");
        rd_now(3'd2, 8'hE1, "R9 master status");
        rd_now(3'd3, 8'hE1, "R9 target");
        rd_now(3'd4, 8'h00, "R9 switch ctrl");
        rd_now(3'd5, 8'h18, "R9 divider");
        rd_now(3'd6, 8'h00, "R9 unmapped");
        chk("R9 enables", osc_enable_o, 3'b001);

        // R2 invalid code ignored
        wr(3'd3, 8'h55);
        rd_now(3'd3, 8'hE1, "R2 invalid code");

        // R3 start a switch to the slow source
        wr(3'd3, 8'hD2);
        rd_now(3'd3, 8'hD2, "R1 target write");
        wr(3'd4, 8'h06);
        rd_now(3'd4, 8'h05, "R3 busy set");
        chk("R7 target forced on", osc_enable_o, 3'b011);
        wr(3'd3, 8'hB4);
        rd_now(3'd3, 8'hD2, "R2 locked while busy");

        // R6 single-edge ready pulse does not complete
        @(negedge clk); osc_ready_i = 3'b011;
        @(negedge clk); osc_ready_i = 3'b001;
        repeat (3) @(negedge clk);
        rd_now(3'd4, 8'h05, "R6 still busy after pulse");
        rd_now(3'd2, 8'hE1, "R6 master unchanged");

        // R6 two consecutive samples complete
        osc_ready_i = 3'b011;
        rd_chk(3'd4, 8'h05, "R6 busy after first sample");
        rd_chk(3'd2, 8'hD2, "R3 master updated");
        rd_now(3'd4, 8'h0C, "R5 flag set busy clear");
        chk("R5 irq raised", irq_o, 1);

        // R5 clear flag
        wr(3'd4, 8'h04);
        rd_now(3'd4, 8'h04, "R5 flag cleared");
        chk("R5 irq low", irq_o, 0);

        // R4 abort
        wr(3'd3, 8'hB4);
        wr(3'd4, 8'h06);
        rd_now(3'd4, 8'h05, "R3 busy for ext");
        repeat (2) @(negedge clk);
        wr(3'd4, 8'h04);
        rd_now(3'd4, 8'h04, "R4 busy cleared by abort");
        rd_now(3'd2, 8'hD2, "R4 master kept");

        // R3 same-source start
        wr(3'd3, 8'hD2);
        wr(3'd4, 8'h06);
        rd_now(3'd4, 8'h04, "R3 no busy for same source");
        rd_now(3'd2, 8'hD2, "R3 master same");

        // R5 flag without interrupt enable
        wr(3'd3, 8'hB4);
        osc_ready_i = 3'b111;
        wr(3'd4, 8'h02);
        repeat (2) @(negedge clk);
        rd_now(3'd2, 8'hB4, "R6 switched to ext");
        rd_now(3'd4, 8'h08, "R5 flag with ie off");
        chk("R5 irq gated", irq_o, 0);

        // R7 oscillator registers
        wr(3'd0, 8'h05);
        rd_now(3'd0, 8'h0F, "R7 int reg");
        wr(3'd1, 8'h01);
        rd_now(3'd1, 8'h03, "R7 ext reg");
        chk("R7 all enabled", osc_enable_o, 3'b111);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        chk("R7 master only", osc_enable_o, 3'b100);
        rd_now(3'd0, 8'h0A, "R7 ready follows input");

        // R8 divider
        wr(3'd5, 8'h09);
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            #2;
            if (cpu_tick_o) ticks++;
            @(negedge clk);
        end
        chk("R8 divide by 4 count", ticks, 10);
        wr(3'd5, 8'h00);
        ticks = 0;
        for (int i = 0; i < 8; i++) begin
            #2;
            if (cpu_tick_o) ticks++;
            @(negedge clk);
        end
        chk("R8 divide by 1 count", ticks, 8);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            bus_wr   = ($urandom % 4) == 0;
            bus_addr = 3'($urandom % 7);
            case ($urandom % 4)
                0: bus_wdata = 8'hE1;
                1: bus_wdata = 8'hD2;
                2: bus_wdata = 8'hB4;
                default: bus_wdata = 8'($urandom);
            endcase
            if (bus_addr == 3'd4) bus_wdata = 8'($urandom) | 8'h01;
            if (($urandom % 8) == 0) bus_wdata[0] = 1'b0;
            if (bus_addr == 3'd5 && ($urandom % 4) != 0) bus_wr = 1'b0;
            osc_ready_i = 3'(($urandom % 8) | ($urandom % 8));
        end
        @(negedge clk);
        bus_wr = 1'b0;

        // R9 reset again
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd_now(3'd2, 8'hE1, "R9 master after reset");
        rd_now(3'd5, 8'h18, "R9 divider after reset");
        rd_now(3'd4, 8'h00, "R9 ctrl after reset");

        finish_run();
    end

endmodule